// File: doc/BRIEF.md
# Activation Sampler with Victim-Refresh Inhibitor

This block sits next to one DRAM bank and defends it against repeated row activation. It watches each accepted row-activate strobe and keeps a small table of rows that may be aggressors, each with its own activation count. Which new rows may enter the table is chosen by a selectable policy:

- every Nth activation;
- the first N activations after a refresh;
- a 16-bit pseudo-random draw compared against a threshold;
- no sampling at all.

The block never acts when an activation arrives. When a regular refresh command is accepted, a small state machine looks for a candidate: a valid entry whose count is above a threshold. It picks the entry with the highest count. It then issues a single victim-refresh strobe for a row next to that aggressor, and clears the entry. The victim strobe appears a fixed two cycles after the refresh, which fits inside the normal refresh latency. It therefore adds no cycles to what the controller sees.

The controller drives activate and refresh strobes exactly as it would for the bank. It does not interact with the block in any other way.

The state machine has three states:

- `ST_IDLE`: waits for a refresh and accepts activations.
- `ST_SELECT`: evaluates the table.
- `ST_ISSUE`: drives the victim strobe and clears the chosen entry.

Its transitions are:

- `ST_IDLE` to `ST_SELECT` when a refresh is accepted.
- `ST_SELECT` to `ST_ISSUE` when a candidate exists.
- `ST_SELECT` to `ST_IDLE` when no candidate exists.
- `ST_ISSUE` to `ST_IDLE` always.

Top module: `trr_guard`

## Requirements
- R1: After reset the table is empty and `vic_valid` is low; a refresh with no intervening activations produces no victim.
- R2: Every accepted activation of a tracked row increments that row's count (saturating), whatever the policy; a row is a candidate only when its count exceeds THRESH (default 3, so 4 activations qualify and 3 do not).
- R3: With `samp_mode` = 2'd0 a new row may be allocated only on every NTH-th accepted activation (default 4), counted over all accepted activations since reset.
- R4: With `samp_mode` = 2'd1 a new row may be allocated only among the first FIRST_N (default 4) accepted activations since the last accepted refresh or reset.
- R5: With `samp_mode` = 2'd2 a new row is allocated when the 16-bit LFSR value is less than or equal to `rand_thresh` (0 never succeeds, 16'hFFFF always does); with `samp_mode` = 2'd3 nothing is allocated.
- R6: The table holds ENTRIES (default 4) distinct rows; once full, activations of further distinct rows are not tracked and change no entry.
- R7: A victim strobe appears only as a result of a refresh, exactly two cycles after the refresh strobe is sampled; activations never cause one.
- R8: Each refresh yields at most one victim; the chosen aggressor is the candidate with the highest count (lowest slot on a tie), it is cleared, and the other entries persist for later refreshes.
- R9: The victim is aggressor-1, except that when the same aggressor row was the previous choice the other side is used (alternating); aggressor row 0 always gives row 1 and the maximum row always gives maximum-1.
- R10: Activations that coincide with a refresh strobe, and activations or refreshes while the block is in `ST_SELECT` or `ST_ISSUE`, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | Row-activate strobe |
| act_row | input | ROW_W | Row address of the activation |
| ref_valid | input | 1 | Regular refresh command strobe |
| samp_mode | input | 2 | Sampling policy: 0 every Nth, 1 first N, 2 random, 3 off |
| rand_thresh | input | 16 | Success threshold for the random policy |
| vic_valid | output | 1 | Victim-refresh strobe, one cycle |
| vic_row | output | ROW_W | Row to refresh, valid with `vic_valid` |

## Verification
Several properties are checked on every cycle:

- the victim strobe always trails a refresh by two cycles;
- the strobe never stays high for two cycles in a row;
- the victim row is always next to the candidate row that was picked;
- at most one table entry matches any row;
- a full table is left unchanged by an unknown row;
- the first-N window reopens after each refresh.

Some behaviours can only be shown by the bench's scenarios:

- which aggressor wins among several candidates;
- the exact count threshold;
- each sampling policy's allocation pattern;
- the alternation and clamping of victim sides;
- activations or refreshes that arrive while the state machine is busy being dropped.

// File: rtl/trr_pkg.sv
package trr_pkg;

    typedef enum logic [1:0] {
        SAMP_NTH   = 2'd0,
        SAMP_FIRST = 2'd1,
        SAMP_RAND  = 2'd2,
        SAMP_OFF   = 2'd3
    } samp_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SELECT = 2'd1,
        ST_ISSUE  = 2'd2
    } trr_state_e;

    localparam int LFSR_W = 16;

endpackage

// File: rtl/trr_policy.sv
module trr_policy
    import trr_pkg::*;
#(
    parameter int NTH       = 4,
    parameter int FIRST_N   = 4,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_en,
    input  logic              ref_en,
    input  samp_mode_e        mode,
    input  logic [LFSR_W-1:0] rand_thresh,
    output logic              alloc_ok
);

    localparam int NTH_W = (NTH > 1) ? $clog2(NTH) : 1;
    localparam int FST_W = $clog2(FIRST_N + 1);

    logic [NTH_W-1:0]  nth_cnt;
    logic [FST_W-1:0]  first_cnt;
    logic [LFSR_W-1:0] lfsr;
    logic              fb;

    assign fb = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nth_cnt   <= '0;
            first_cnt <= '0;
            lfsr      <= LFSR_SEED;
        end else begin
            if (act_en) begin
                nth_cnt <= (nth_cnt == NTH_W'(NTH - 1)) ? '0 : nth_cnt + 1'b1;
                if (first_cnt < FST_W'(FIRST_N))
                    first_cnt <= first_cnt + 1'b1;
                lfsr <= {lfsr[LFSR_W-2:0], fb};
            end
            if (ref_en)
                first_cnt <= '0;
        end
    end

    always_comb begin
        unique case (mode)
            SAMP_NTH:   alloc_ok = (nth_cnt == NTH_W'(NTH - 1));
            SAMP_FIRST: alloc_ok = (first_cnt < FST_W'(FIRST_N));
            SAMP_RAND:  alloc_ok = (lfsr <= rand_thresh);
            SAMP_OFF:   alloc_ok = 1'b0;
            default:    alloc_ok = 1'b0;
        endcase
    end

    // R4
    first_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_en && mode == SAMP_FIRST) |=> (mode != SAMP_FIRST || alloc_ok));

    // R5
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0);

endmodule

// File: rtl/trr_table.sv
module trr_table #(
    parameter int ENTRIES = 4,
    parameter int ROW_W   = 8,
    parameter int CNT_W   = 8,
    parameter int THRESH  = 3
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       act_en,
    input  logic [ROW_W-1:0]                           act_row,
    input  logic                                       alloc_ok,
    input  logic                                       clr_en,
    input  logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] clr_idx,
    output logic                                       cand_found,
    output logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] cand_idx,
    output logic [ROW_W-1:0]                           cand_row
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [ENTRIES-1:0]            vld;
    logic [ENTRIES-1:0][ROW_W-1:0] rows;
    logic [ENTRIES-1:0][CNT_W-1:0] cnts;
    logic [ENTRIES-1:0]            hit;
    logic                          any_hit, any_free;
    logic [IDX_W-1:0]              hit_idx, free_idx;
    logic [CNT_W-1:0]              best_cnt;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign hit[g] = vld[g] && (rows[g] == act_row);
    end

    always_comb begin
        any_hit  = 1'b0;
        hit_idx  = '0;
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any_hit = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!vld[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        cand_found = 1'b0;
        cand_idx   = '0;
        cand_row   = '0;
        best_cnt   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vld[i] && cnts[i] > CNT_W'(THRESH) && (!cand_found || cnts[i] > best_cnt)) begin
                cand_found = 1'b1;
                cand_idx   = IDX_W'(i);
                cand_row   = rows[i];
                best_cnt   = cnts[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= '0;
            rows <= '0;
            cnts <= '0;
        end else begin
            if (clr_en)
                vld[clr_idx] <= 1'b0;
            if (act_en) begin
                if (any_hit) begin
                    if (cnts[hit_idx] != CNT_MAX)
                        cnts[hit_idx] <= cnts[hit_idx] + 1'b1;
                end else if (alloc_ok && any_free) begin
                    vld[free_idx]  <= 1'b1;
                    rows[free_idx] <= act_row;
                    cnts[free_idx] <= CNT_W'(1);
                end
            end
        end
    end

    // R6
    unique_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R6
    full_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && !any_hit && (&vld) && !clr_en) |=> ($stable(rows) && $stable(vld)));

endmodule

// File: rtl/trr_guard.sv
module trr_guard
    import trr_pkg::*;
#(
    parameter int ROW_W   = 8,
    parameter int ENTRIES = 4,
    parameter int CNT_W   = 8,
    parameter int THRESH  = 3,
    parameter int NTH     = 4,
    parameter int FIRST_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_valid,
    input  logic [ROW_W-1:0] act_row,
    input  logic             ref_valid,
    input  logic [1:0]       samp_mode,
    input  logic [15:0]      rand_thresh,
    output logic             vic_valid,
    output logic [ROW_W-1:0] vic_row
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [ROW_W-1:0] ROW_MAX = '1;

    trr_state_e       state, state_nxt;
    logic             act_en, ref_en, alloc_ok, clr_en, go_up;
    logic             cand_found;
    logic [IDX_W-1:0] cand_idx, sel_idx;
    logic [ROW_W-1:0] cand_row, vic_row_q, last_row;
    logic             last_up, last_vld;

    assign act_en = act_valid && !ref_valid && (state == ST_IDLE);
    assign ref_en = ref_valid && (state == ST_IDLE);

    trr_policy #(.NTH(NTH), .FIRST_N(FIRST_N)) u_policy (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_en      (act_en),
        .ref_en      (ref_en),
        .mode        (samp_mode_e'(samp_mode)),
        .rand_thresh (rand_thresh),
        .alloc_ok    (alloc_ok)
    );

    trr_table #(.ENTRIES(ENTRIES), .ROW_W(ROW_W), .CNT_W(CNT_W), .THRESH(THRESH)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_en     (act_en),
        .act_row    (act_row),
        .alloc_ok   (alloc_ok),
        .clr_en     (clr_en),
        .clr_idx    (sel_idx),
        .cand_found (cand_found),
        .cand_idx   (cand_idx),
        .cand_row   (cand_row)
    );

    always_comb begin
        unique case (state)
            ST_IDLE:   state_nxt = ref_en ? ST_SELECT : ST_IDLE;
            ST_SELECT: state_nxt = cand_found ? ST_ISSUE : ST_IDLE;
            ST_ISSUE:  state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        if (cand_row == '0)                                 go_up = 1'b1;
        else if (cand_row == ROW_MAX)                       go_up = 1'b0;
        else if (last_vld && last_row == cand_row)          go_up = !last_up;
        else                                                go_up = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx   <= '0;
            vic_row_q <= '0;
            last_row  <= '0;
            last_up   <= 1'b0;
            last_vld  <= 1'b0;
        end else if (state == ST_SELECT && cand_found) begin
            sel_idx   <= cand_idx;
            vic_row_q <= go_up ? cand_row + ROW_W'(1) : cand_row - ROW_W'(1);
            last_row  <= cand_row;
            last_up   <= go_up;
            last_vld  <= 1'b1;
        end
    end

    always_comb begin
        vic_valid = (state == ST_ISSUE);
        vic_row   = vic_row_q;
        clr_en    = (state == ST_ISSUE);
    end

    // R7
    vic_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |-> $past(ref_valid, 2));

    // R8
    one_vic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |=> !vic_valid);

    // R9
    vic_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |-> (vic_row == ROW_W'($past(cand_row) + 1'b1) ||
                       vic_row == ROW_W'($past(cand_row) - 1'b1)));

endmodule

// File: tb/tb_trr_guard.sv
`timescale 1ns/1ps
module tb_trr_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        act_valid = 1'b0;
    logic [7:0]  act_row = '0;
    logic        ref_valid = 1'b0;
    logic [1:0]  samp_mode = 2'd1;
    logic [15:0] rand_thresh = '0;
    logic        vic_valid;
    logic [7:0]  vic_row;

    int checks = 0;
    int errors = 0;
    int    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    trr_guard dut (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_row(act_row),
        .ref_valid(ref_valid), .samp_mode(samp_mode), .rand_thresh(rand_thresh),
        .vic_valid(vic_valid), .vic_row(vic_row)
    );

    // monitor: pops the expected victim whenever the design issues one
    always @(negedge clk) begin
        if (rst_n && vic_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R7 unexpected victim actual=%0d expected=none", vic_row);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (vic_row !== 8'(e)) begin
                    errors++;
                    $display("FAIL %s victim row actual=%0d expected=%0d", t, vic_row, e);
                end
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        act_valid = 1'b0;
        ref_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic act(input int row, input int n);
        repeat (n) begin
            @(negedge clk);
            act_valid = 1'b1;
            act_row   = 8'(row);
            @(negedge clk);
            act_valid = 1'b0;
        end
    endtask

    task automatic expect_vic(input int row, input string tag);
        if (row >= 0) begin
            exp_q.push_back(row);
            tag_q.push_back(tag);
        end
    endtask

    task automatic settle(input string tag);
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s missing victim actual=none expected=%0d", tag, exp_q[0]);
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    task automatic do_ref(input int row, input string tag);
        expect_vic(row, tag);
        @(negedge clk);
        ref_valid = 1'b1;
        @(negedge clk);
        ref_valid = 1'b0;
        settle(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        samp_mode = 2'd1;
        do_reset();
        @(negedge clk);
        checks++;
        if (vic_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 vic_valid after reset actual=%b expected=0", vic_valid);
        end
        do_ref(-1, "R1");

        // R2 R4 R9: four hits qualify, first victim is row-1
        act(10, 4);
        do_ref(9, "R2");
        // R2: three activations do not qualify, entry persists
        do_ref(-1, "R2");
        act(20, 3);
        do_ref(-1, "R2");
        act(20, 1);
        do_ref(19, "R2");
        // R9: same aggressor again takes the other side
        act(20, 4);
        do_ref(21, "R9");
        // R9: clamps at row 0 and the top row
        act(0, 4);
        do_ref(1, "R9");
        act(0, 4);
        do_ref(1, "R9");
        act(255, 4);
        do_ref(254, "R9");
        // R4: window of four allocations after a refresh
        act(30, 4);
        act(40, 5);
        do_ref(29, "R4");
        do_ref(-1, "R4");

        // R3: every fourth activation may allocate
        samp_mode = 2'd0;
        do_reset();
        act(50, 3);
        act(60, 5);
        do_ref(59, "R3");
        do_ref(-1, "R3");

        // R5: random policy with never / always thresholds, and off mode
        samp_mode = 2'd2;
        rand_thresh = 16'h0000;
        do_reset();
        act(70, 6);
        do_ref(-1, "R5");
        rand_thresh = 16'hFFFF;
        act(71, 4);
        do_ref(70, "R5");
        samp_mode = 2'd3;
        do_reset();
        act(80, 6);
        do_ref(-1, "R5");

        // R6 R8: full table, priority, persistence
        samp_mode = 2'd2;
        rand_thresh = 16'hFFFF;
        do_reset();
        act(100, 5);
        act(110, 6);
        act(120, 4);
        act(130, 6);
        act(140, 8);
        do_ref(109, "R8");
        do_ref(129, "R8");
        do_ref(99, "R8");
        do_ref(119, "R8");
        do_ref(-1, "R6");

        // R10: activations with or right after a refresh are ignored
        do_reset();
        act(150, 4);
        act(160, 3);
        expect_vic(149, "R10");
        @(negedge clk);
        ref_valid = 1'b1;
        act_valid = 1'b1;
        act_row   = 8'd160;
        @(negedge clk);
        ref_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        act_valid = 1'b0;
        settle("R10");
        do_ref(-1, "R10");
        act(160, 1);
        act(170, 4);
        // R10: a refresh held into the busy state gives only one victim
        expect_vic(169, "R10");
        @(negedge clk);
        ref_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        ref_valid = 1'b0;
        settle("R10");
        do_ref(159, "R10");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule